// File: doc/BRIEF.md
# Four-Way Recent-Use Victim Tracker

This block keeps two way numbers, A (the older recent entry) and B (the newer one), for a four-way set. It also offers a third way that differs from both. On every cycle with the touch strobe high it reads the 2-bit index of the way just used. If that way is A, the old B moves into A and B is refilled with the offered way. If it is B, only B is refilled. A touch of any other way leaves both registers alone. The offered way is a fixed function of the current A and B, so a cache controller can take it as its next victim without looking it up.

A state with A equal to B is inconsistent. The block shows it on a plain status pin. The next touch, whatever way it names, refills B, which clears the condition in one cycle. Two combinations in which one register holds way 0 and the other holds way 3 have explicit next-state overrides. The touch input is a plain strobe with no ready signal: the block never applies back-pressure and takes a touch on every clock edge where the strobe is high.

Top module: `vtrk_top`

## Requirements
- R1: A synchronous active-high reset loads A with parameter RESET_A (default 00) and B with RESET_B (default 01). With the defaults the error pin is low after reset.
- R2: The offered way depends only on A and B. When neither is 11 it is the bitwise inverse of A XOR B. Otherwise take X as B if A is 11, else A, and map X 00->01, 01->10, 10->01, 11->00. The offered way never equals A or B.
- R3: A touch of way A, with A different from B, loads A with the old B and B with the offered way.
- R4: A touch of way B, with A different from B, keeps A and loads B with the offered way.
- R5: A touch of a way equal to neither A nor B leaves A and B unchanged.
- R6: With the strobe low, A and B keep their values whatever the way input carries.
- R7: The error pin is high exactly while A equals B, with no register in between. A touch in that state keeps A and loads B with the offered way whatever the way input is, so the pin is low one cycle later.
- R8: From A=00, B=11, a touch of way 00 gives A=11, B=01. From A=11, B=00, a touch of way 11 gives A=00, B=01.
- R9: The next A is always the old A or the old B. Starting from a reset with A different from B, the error pin never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| touch_i | input | 1 | Access strobe, one access per high cycle |
| touch_way_i | input | 2 | Index of the way accessed |
| recent_a_o | output | 2 | Registered A, the older recent way |
| recent_b_o | output | 2 | Registered B, the newer recent way |
| offer_o | output | 2 | Offered way, combinational from A and B |
| clash_o | output | 1 | High while A equals B |

## Verification
A wrong entry in the offered-way map shows up on B in the cycle right after the touch. It then spreads into A one touch later, once B is promoted. A bad rule choice shows up as a register that moves on a miss or an idle cycle, or that stays put on a hit, on the very next edge. Reaching the states that hold way 11, and the clash state, takes instances whose reset values are set to equal pairs. The recovery path is then seen as the clash pin dropping one cycle after the touch, and the two overrides are reached one touch after that.

// File: rtl/vtrk_pkg.sv
package vtrk_pkg;
  localparam int WAY_W = 2;
  localparam int N_WAYS = 1 << WAY_W;

  typedef logic [WAY_W-1:0] way_t;

  typedef enum logic [2:0] {
    UPD_HOLD  = 3'd0,
    UPD_HIT_A = 3'd1,
    UPD_HIT_B = 3'd2,
    UPD_FIX   = 3'd3,
    UPD_OVR   = 3'd4
  } upd_e;

  localparam way_t WAY_LO = way_t'(0);
  localparam way_t WAY_HI = way_t'(N_WAYS - 1);
  localparam way_t OVR_B  = way_t'(1);
endpackage

// File: rtl/vtrk_pick.sv
module vtrk_pick
  import vtrk_pkg::*;
(
  input  way_t a_i,
  input  way_t b_i,
  output way_t fresh_o
);
  logic a_top, b_top;
  way_t other;

  assign a_top = (a_i == WAY_HI);
  assign b_top = (b_i == WAY_HI);
  assign other = a_top ? b_i : a_i;

  always_comb begin
    if (!a_top && !b_top) begin
      fresh_o = ~(a_i ^ b_i);
    end else begin
      unique case (other)
        2'b00:   fresh_o = 2'b01;
        2'b01:   fresh_o = 2'b10;
        2'b10:   fresh_o = 2'b01;
        default: fresh_o = 2'b00;
      endcase
    end
  end
endmodule

// File: rtl/vtrk_next.sv
module vtrk_next
  import vtrk_pkg::*;
(
  input  logic touch_i,
  input  way_t way_i,
  input  way_t a_i,
  input  way_t b_i,
  input  way_t fresh_i,
  output upd_e kind_o,
  output way_t nxt_a_o,
  output way_t nxt_b_o
);
  logic ovr_lo, ovr_hi;

  assign ovr_lo = (a_i == WAY_LO) && (b_i == WAY_HI) && (way_i == WAY_LO);
  assign ovr_hi = (a_i == WAY_HI) && (b_i == WAY_LO) && (way_i == WAY_HI);

  always_comb begin
    if (!touch_i)                kind_o = UPD_HOLD;
    else if (a_i == b_i)         kind_o = UPD_FIX;
    else if (ovr_lo || ovr_hi)   kind_o = UPD_OVR;
    else if (way_i == a_i)       kind_o = UPD_HIT_A;
    else if (way_i == b_i)       kind_o = UPD_HIT_B;
    else                         kind_o = UPD_HOLD;
  end

  always_comb begin
    nxt_a_o = a_i;
    nxt_b_o = b_i;
    unique case (kind_o)
      UPD_HIT_A: begin nxt_a_o = b_i; nxt_b_o = fresh_i; end
      UPD_HIT_B: nxt_b_o = fresh_i;
      UPD_FIX:   nxt_b_o = fresh_i;
      UPD_OVR:   begin nxt_a_o = b_i; nxt_b_o = OVR_B; end
      default:   ;
    endcase
  end
endmodule

// File: rtl/vtrk_state.sv
module vtrk_state
  import vtrk_pkg::*;
#(
  parameter way_t RESET_A = 2'b00,
  parameter way_t RESET_B = 2'b01
) (
  input  logic clk_i,
  input  logic rst_i,
  input  upd_e kind_i,
  input  way_t nxt_a_i,
  input  way_t nxt_b_i,
  output way_t a_o,
  output way_t b_o
);
  logic load;
  assign load = (kind_i != UPD_HOLD);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      a_o <= RESET_A;
      b_o <= RESET_B;
    end else if (load) begin
      a_o <= nxt_a_i;
      b_o <= nxt_b_i;
    end
  end
endmodule

// File: rtl/vtrk_top.sv
module vtrk_top
  import vtrk_pkg::*;
#(
  parameter way_t RESET_A = 2'b00,
  parameter way_t RESET_B = 2'b01
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       touch_i,
  input  logic [1:0] touch_way_i,
  output logic [1:0] recent_a_o,
  output logic [1:0] recent_b_o,
  output logic [1:0] offer_o,
  output logic       clash_o
);
  way_t a_q, b_q, fresh, nxt_a, nxt_b;
  upd_e kind;

  vtrk_pick u_pick (.a_i(a_q), .b_i(b_q), .fresh_o(fresh));

  vtrk_next u_next (
    .touch_i(touch_i), .way_i(touch_way_i), .a_i(a_q), .b_i(b_q),
    .fresh_i(fresh), .kind_o(kind), .nxt_a_o(nxt_a), .nxt_b_o(nxt_b)
  );

  vtrk_state #(.RESET_A(RESET_A), .RESET_B(RESET_B)) u_state (
    .clk_i(clk_i), .rst_i(rst_i), .kind_i(kind),
    .nxt_a_i(nxt_a), .nxt_b_i(nxt_b), .a_o(a_q), .b_o(b_q)
  );

  assign recent_a_o = a_q;
  assign recent_b_o = b_q;
  assign offer_o    = fresh;
  assign clash_o    = (a_q == b_q);

  p_offer_distinct_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (offer_o != recent_a_o) && (offer_o != recent_b_o));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !touch_i |=> $stable(recent_a_o) && $stable(recent_b_o));

  p_miss_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (touch_i && !clash_o && touch_way_i != recent_a_o && touch_way_i != recent_b_o)
    |=> $stable(recent_a_o) && $stable(recent_b_o));

  p_hit_b_keeps_a_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (touch_i && !clash_o && touch_way_i == recent_b_o) |=> $stable(recent_a_o));

  p_hit_a_promotes_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (touch_i && !clash_o && touch_way_i == recent_a_o)
    |=> recent_a_o == $past(recent_b_o));

  p_a_from_old_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    touch_i |=> (recent_a_o == $past(recent_a_o)) || (recent_a_o == $past(recent_b_o)));

  p_clash_clears_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (touch_i && clash_o) |=> !clash_o);
endmodule

// File: tb/vtrk_top_tb_top.sv
module vtrk_top_tb_top;
  localparam int CLK_NS = 20;
  localparam int NV = 14;
  // {touch, way[1:0], exp_a[1:0], exp_b[1:0]} ; start A=00 B=01
  localparam logic [6:0] VEC [NV] = '{
    7'b1_00_01_10, 7'b1_11_01_10, 7'b0_01_01_10, 7'b1_10_01_00,
    7'b1_01_00_10, 7'b1_10_00_01, 7'b1_01_00_10, 7'b1_00_10_01,
    7'b0_10_10_01, 7'b1_10_01_00, 7'b1_00_01_10, 7'b1_01_10_00,
    7'b1_10_00_01, 7'b1_11_00_01
  };
  // 3 = hit A, 4 = hit B, 5 = miss, 6 = idle
  localparam int KIND [NV] = '{3, 5, 6, 4, 3, 4, 4, 3, 6, 3, 4, 3, 3, 5};

  logic clk = 1'b0, rst = 1'b1;
  logic t0 = 0, t1 = 0, t2 = 0;
  logic [1:0] w0 = 0, w1 = 0, w2 = 0;
  logic [1:0] a0, b0, o0, a1, b1, o1, a2, b2, o2;
  logic c0, c1, c2;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  vtrk_top dut_i (.clk_i(clk), .rst_i(rst), .touch_i(t0), .touch_way_i(w0),
    .recent_a_o(a0), .recent_b_o(b0), .offer_o(o0), .clash_o(c0));
  vtrk_top #(.RESET_A(2'b00), .RESET_B(2'b00)) dut_lo (.clk_i(clk), .rst_i(rst),
    .touch_i(t1), .touch_way_i(w1), .recent_a_o(a1), .recent_b_o(b1),
    .offer_o(o1), .clash_o(c1));
  vtrk_top #(.RESET_A(2'b11), .RESET_B(2'b11)) dut_hi (.clk_i(clk), .rst_i(rst),
    .touch_i(t2), .touch_way_i(w2), .recent_a_o(a2), .recent_b_o(b2),
    .offer_o(o2), .clash_o(c2));

  task automatic chk(input string tag, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got={a,b,clash}=%b exp=%b", tag, got, exp);
    end
  endtask

  function automatic string kname(input int k);
    case (k)
      3: return "R3 R2 hit A";
      4: return "R4 R2 hit B";
      5: return "R5 miss";
      default: return "R6 idle";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset", {a0, b0, c0}, 5'b00_01_0);
    chk("R7 clash after equal reset lo", {a1, b1, c1}, 5'b00_00_1);
    chk("R7 clash after equal reset hi", {a2, b2, c2}, 5'b11_11_1);

    for (int i = 0; i < NV; i++) begin
      t0 = VEC[i][6];
      w0 = VEC[i][5:4];
      @(negedge clk);
      chk(kname(KIND[i]), {a0, b0, c0}, {VEC[i][3:0], 1'b0});
      checks++;
      if (c0 !== 1'b0 || o0 == a0 || o0 == b0) begin
        failures++;
        $display("FAIL R9 R2 clash=%b offer=%b a=%b b=%b exp clash=0 offer distinct",
                 c0, o0, a0, b0);
      end
    end
    t0 = 1'b0;

    // clash path and override from A=00 B=11
    @(negedge clk);
    chk("R7 R6 clash held while idle", {a1, b1, c1}, 5'b00_00_1);
    t1 = 1'b1; w1 = 2'b10;
    @(negedge clk);
    chk("R7 forced refill", {a1, b1, c1}, 5'b00_11_0);
    w1 = 2'b00;
    @(negedge clk);
    chk("R8 override lo", {a1, b1, c1}, 5'b11_01_0);
    w1 = 2'b11;
    @(negedge clk);
    chk("R3 R2 hit A with A=11", {a1, b1, c1}, 5'b01_10_0);
    t1 = 1'b0;

    // clash path and override from A=11 B=00
    t2 = 1'b1; w2 = 2'b01;
    @(negedge clk);
    chk("R7 forced refill hi", {a2, b2, c2}, 5'b11_00_0);
    w2 = 2'b11;
    @(negedge clk);
    chk("R8 override hi", {a2, b2, c2}, 5'b00_01_0);
    t2 = 1'b0;

    // reset in the middle of traffic
    t0 = 1'b1; w0 = 2'b00;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    t0 = 1'b0; rst = 1'b0;
    chk("R1 reset mid run", {a0, b0, c0}, 5'b00_01_0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule